// File: doc/BRIEF.md
# Single-Level Vectored Interrupt Controller

This block sits beside a small processor core and turns a group of peripheral interrupt lines into a single request with a vector. A rising edge on any request line latches a flag for that source. A flag counts only when the per-source mask bit for it is set. The masked flags are then gated by one global enable bit. When the core is offered a request, it also receives the word address of the handler slot for the winning source.

Only one level of interrupt exists. When the core accepts a request, the global enable drops in hardware and the flag of the accepted source is cleared, so no second request can be offered while a handler runs. A return strobe from the core turns the global enable back on. A separate set-enable strobe does the same, for start-up. The vector table uses two-word slots. Slot 0 belongs to reset, so source `i` lands at word address `2*(i+1)`.

The asynchronous reset input is synchronised inside the block. Its release takes effect two clock edges after the input goes high.

Top module: `irqc_top`

## Requirements
- R1: After reset, `irq_pending` is 0, `vec_addr` is 0, the global enable is off and no source flag is latched.
- R2: A source flag latches on a 0-to-1 transition of its `irq_req` bit. A line held high does not latch again after the flag is cleared; the line must fall and rise again.
- R3: A latched flag whose `src_en` bit is 0 does not make `irq_pending` 1, and it stays latched. Setting the mask bit later makes the request visible without a new edge.
- R4: `irq_pending` is 1 only when the global enable is on and at least one latched flag has its mask bit set. `gie_set` turns the global enable on from the next cycle.
- R5: `accept` while `irq_pending` is 1 turns the global enable off, so `irq_pending` is 0 in the next cycle. `accept` while `irq_pending` is 0 has no effect.
- R6: `ret_strobe` turns the global enable on from the next cycle.
- R7: Among eligible sources, the lowest index wins. `vec_addr` is `2*(index+1)`: source 0 gives 2 and source 7 gives 16.
- R8: An accepted request clears only the winning source's flag. Other latched flags remain and are offered after the global enable returns.
- R9: `vec_addr` is 0 whenever `irq_pending` is 0.
- R10: If a new rising edge of a source arrives in the same cycle that source is accepted, its flag stays latched.
- R11: If `accept` (with `irq_pending` 1) coincides with `gie_set` or `ret_strobe`, the accept wins and the global enable ends off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_req | input | NUM_SRC | Peripheral request lines, edge detected |
| src_en | input | NUM_SRC | Per-source mask bits, 1 = enabled |
| gie_set | input | 1 | Strobe: turn the global enable on |
| ret_strobe | input | 1 | Strobe: return from handler, turn the global enable on |
| accept | input | 1 | Core takes the offered interrupt this cycle |
| irq_pending | output | 1 | An interrupt is offered to the core |
| vec_addr | output | VEC_W | Word address of the offered handler slot, 0 when idle |

## Verification
The flags and the global enable are internal, so an error in them shows at the ports only as a wrong `irq_pending` or `vec_addr`. That shows up one cycle after the edge, strobe or accept that changed the state, or later, when a mask bit or the return strobe exposes a flag that had been wrongly kept or lost. A behavioural model in the bench tracks each flag and the enable as plain integers. The outputs are compared with this model on every cycle. The stimulus covers held lines, masked flags that are enabled later, accepts with no request offered, and strobes that collide with an accept.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [1:0] {
    GIE_HOLD  = 2'd0,
    GIE_CLEAR = 2'd1,
    GIE_SET   = 2'd2
  } gie_op_e;

  // Word address of the handler slot for a source; slot 0 is reset.
  function automatic int unsigned slot_addr(input int unsigned idx);
    return 2 * (idx + 1);
  endfunction

endpackage

// File: rtl/irqc_edge_latch.sv
module irqc_edge_latch #(
  parameter int unsigned NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req,
  input  logic [NUM_SRC-1:0] clr,
  output logic [NUM_SRC-1:0] flags
);

  logic [NUM_SRC-1:0] prev_q;
  logic [NUM_SRC-1:0] flag_q;
  logic [NUM_SRC-1:0] flag_d;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic rise;
    assign rise = req[g] & ~prev_q[g];

    always_comb begin
      flag_d[g] = flag_q[g];
      if (clr[g]) flag_d[g] = 1'b0;
      if (rise)   flag_d[g] = 1'b1;  // fresh edge outranks clear
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      flag_q <= '0;
    end else begin
      prev_q <= req;
      flag_q <= flag_d;
    end
  end

  assign flags = flag_q;

endmodule

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned VEC_W   = 5
) (
  input  logic [NUM_SRC-1:0] cand,
  output logic               any,
  output logic [NUM_SRC-1:0] grant,
  output logic [VEC_W-1:0]   vec
);
  import irqc_pkg::*;

  always_comb begin
    any   = 1'b0;
    grant = '0;
    vec   = '0;
    // walk downward so the lowest index is written last and wins
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (cand[i]) begin
        any      = 1'b1;
        grant    = '0;
        grant[i] = 1'b1;
        vec      = VEC_W'(slot_addr(i));
      end
    end
  end

endmodule

// File: rtl/irqc_gie.sv
module irqc_gie (
  input  logic              clk,
  input  logic              rst_n,
  input  irqc_pkg::gie_op_e op,
  output logic              gie
);
  import irqc_pkg::*;

  logic gie_q;
  logic gie_d;

  always_comb begin
    unique case (op)
      GIE_CLEAR: gie_d = 1'b0;
      GIE_SET:   gie_d = 1'b1;
      default:   gie_d = gie_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gie_q <= 1'b0;
    else        gie_q <= gie_d;
  end

  assign gie = gie_q;

endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
  parameter int unsigned NUM_SRC = 8,
  localparam int unsigned VEC_W  = $clog2(2 * NUM_SRC + 3)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic               gie_set,
  input  logic               ret_strobe,
  input  logic               accept,
  output logic               irq_pending,
  output logic [VEC_W-1:0]   vec_addr
);
  import irqc_pkg::*;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NUM_SRC-1:0] flags;
  logic [NUM_SRC-1:0] cand;
  logic [NUM_SRC-1:0] grant;
  logic [NUM_SRC-1:0] clr;
  logic               any_cand;
  logic [VEC_W-1:0]   enc_vec;
  logic               gie;
  logic               take;
  gie_op_e            op;

  irqc_edge_latch #(.NUM_SRC(NUM_SRC)) u_latch (
    .clk   (clk),
    .rst_n (rst_int_n),
    .req   (irq_req),
    .clr   (clr),
    .flags (flags)
  );

  assign cand = flags & src_en;

  irqc_prio_enc #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_enc (
    .cand  (cand),
    .any   (any_cand),
    .grant (grant),
    .vec   (enc_vec)
  );

  always_comb begin
    irq_pending = gie & any_cand;
    take        = accept & irq_pending;
    clr         = take ? grant : '0;
    vec_addr    = irq_pending ? enc_vec : '0;
    if (take)                      op = GIE_CLEAR;
    else if (gie_set | ret_strobe) op = GIE_SET;
    else                           op = GIE_HOLD;
  end

  irqc_gie u_gie (
    .clk   (clk),
    .rst_n (rst_int_n),
    .op    (op),
    .gie   (gie)
  );

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned VEC_W   = 5
) (
  input logic               clk,
  input logic               rst_int_n,
  input logic [NUM_SRC-1:0] src_en,
  input logic               ret_strobe,
  input logic               accept,
  input logic               irq_pending,
  input logic [VEC_W-1:0]   vec_addr,
  input logic [NUM_SRC-1:0] flags,
  input logic               gie
);

  assert_masked_quiet_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_pending |-> ((flags & src_en) != '0));

  assert_needs_gie_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    !gie |-> !irq_pending);

  assert_accept_blocks_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (accept && irq_pending) |=> !irq_pending);

  assert_return_enables_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ret_strobe && !(accept && irq_pending)) |=> gie);

  assert_slot_shape_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_pending |-> (vec_addr[0] == 1'b0 && vec_addr != '0 &&
                     32'(vec_addr) <= 2 * NUM_SRC));

  assert_idle_vector_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    !irq_pending |-> vec_addr == '0);

  assert_collide_off_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    (accept && irq_pending) |=> !gie);

endmodule

bind irqc_top irqc_checker #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_chk (
  .clk         (clk),
  .rst_int_n   (rst_int_n),
  .src_en      (src_en),
  .ret_strobe  (ret_strobe),
  .accept      (accept),
  .irq_pending (irq_pending),
  .vec_addr    (vec_addr),
  .flags       (flags),
  .gie         (gie)
);

// File: tb/irqc_top_tb.sv
module irqc_top_tb_top;
  localparam int N = 8;
  localparam int VW = $clog2(2 * N + 3);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_req = '0;
  logic [N-1:0]  src_en = '0;
  logic          gie_set = 1'b0;
  logic          ret_strobe = 1'b0;
  logic          accept = 1'b0;
  logic          irq_pending;
  logic [VW-1:0] vec_addr;

  always #5 clk = ~clk;

  irqc_top #(.NUM_SRC(N)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_req     (irq_req),
    .src_en      (src_en),
    .gie_set     (gie_set),
    .ret_strobe  (ret_strobe),
    .accept      (accept),
    .irq_pending (irq_pending),
    .vec_addr    (vec_addr)
  );

  int    checks = 0;
  int    fails = 0;
  string phase = "R1";
  bit    cmp_on = 1'b0;
  bit    done = 1'b0;

  // behavioural reference
  int m_flag[N];
  int m_prev[N];
  int m_gie;

  function automatic int m_sel();
    for (int i = 0; i < N; i++)
      if (m_flag[i] != 0 && src_en[i]) return i;
    return -1;
  endfunction

  function automatic int exp_pend();
    return (m_gie != 0 && m_sel() >= 0) ? 1 : 0;
  endfunction

  function automatic int exp_vec();
    return exp_pend() != 0 ? 2 * (m_sel() + 1) : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin m_flag[i] = 0; m_prev[i] = 0; end
      m_gie = 0;
    end else begin
      int s;
      int take;
      s = m_sel();
      take = (accept && exp_pend() != 0) ? 1 : 0;
      for (int i = 0; i < N; i++) begin
        if (take != 0 && i == s) m_flag[i] = 0;
        if (irq_req[i] && m_prev[i] == 0) m_flag[i] = 1;
        m_prev[i] = irq_req[i] ? 1 : 0;
      end
      if (take != 0) m_gie = 0;
      else if (gie_set || ret_strobe) m_gie = 1;
    end
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      check(phase, "irq_pending", int'(irq_pending), exp_pend());
      check(phase, "vec_addr", int'(vec_addr), exp_vec());
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic strobe_accept(); accept = 1; tick(); accept = 0; endtask
  task automatic strobe_ret();    ret_strobe = 1; tick(); ret_strobe = 0; endtask
  task automatic strobe_set();    gie_set = 1; tick(); gie_set = 0; endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(5);
    // R1: reset values, hand-checked
    check("R1", "irq_pending after reset", int'(irq_pending), 0);
    check("R1", "vec_addr after reset", int'(vec_addr), 0);
    cmp_on = 1'b1;

    // R4: latched and enabled but global enable still off
    phase = "R4";
    src_en = 8'hFE;
    irq_req[3] = 1; tick(2);
    check("R4", "pending with enable off", int'(irq_pending), 0);
    strobe_set(); tick();
    check("R7", "vec of source 3", int'(vec_addr), 8);

    // R7 / R3: lower source wins, masked source 0 is ignored
    phase = "R7";
    irq_req[1] = 1; irq_req[0] = 1; tick(2);
    check("R3", "masked source 0 not chosen", int'(vec_addr), 4);

    // R5 / R8: accept clears enable and source 1 only
    phase = "R5";
    strobe_accept(); tick();
    check("R5", "pending after accept", int'(irq_pending), 0);
    phase = "R5"; strobe_accept(); tick();   // accept while idle: ignored
    phase = "R8"; strobe_ret(); tick();
    check("R8", "source 3 still offered", int'(vec_addr), 8);

    // R6: return restores enable after taking source 3
    phase = "R6";
    strobe_accept(); tick(); strobe_ret(); tick(2);

    // R3: source 0 still latched, appears when unmasked
    phase = "R3";
    src_en = 8'hFF; tick();
    check("R3", "source 0 after unmask", int'(vec_addr), 2);
    strobe_accept(); strobe_ret(); tick(2);

    // R2: held lines do not re-latch; a new edge does
    phase = "R2";
    tick(2);
    irq_req[1] = 0; tick(); irq_req[1] = 1; tick(2);
    strobe_accept(); strobe_ret(); tick(2);

    // R10: new edge during acceptance of the same source
    phase = "R10";
    irq_req[5] = 1; tick(); irq_req[5] = 0; tick(2);
    irq_req[5] = 1; accept = 1; tick(); accept = 0;
    strobe_ret(); tick();
    check("R10", "source 5 relatched", int'(vec_addr), 12);

    // R11: accept colliding with set and return
    phase = "R11";
    accept = 1; gie_set = 1; tick(); accept = 0; gie_set = 0; tick();
    check("R11", "pending after collide", int'(irq_pending), 0);
    strobe_set(); tick();

    // R7 boundary: highest source gives 16
    phase = "R7";
    src_en = 8'h80; irq_req[7] = 1; tick(2);
    check("R7", "vec of source 7", int'(vec_addr), 16);
    strobe_accept(); tick();

    // R9: idle vector
    phase = "R9";
    src_en = '0; strobe_ret(); tick(2);
    check("R9", "vec when idle", int'(vec_addr), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule